// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of a single device function. A configuration agent issues one request per cycle: a byte offset, an access width of one, two or four bytes, a direction and, for writes, the data. The block answers one cycle later with a completion strobe, an error flag and, for reads, the data. Multi-byte data is little-endian and right-justified on the data bus.

Every field that software may not change is a constant built from parameters, so only the command, status, cache line size, latency timer, interrupt line, expansion ROM base and the base address registers are flops. Write permission depends on both the offset and the access width. Each base address register supports the sizing handshake: a write of all ones returns the complement of its size minus one. Its low type bits never change. A normal write also records a decode base and the last address of the decoded window, and these are driven on per-register outputs for the address decoder outside the block.

Top module: `cfgspace_regfile`

## Requirements
- R1: After reset every header byte reads back its parameter value and no base address register reports a valid decode window.
- R2: A read returns the 1, 2 or 4 bytes starting at the offset, lowest offset in bits 7:0 (little-endian), zero-extended to 32 bits. The completion strobe and data appear exactly one cycle after the request, and a write returns data 0.
- R3: A width other than 1, 2 or 4 bytes, a 2-byte access at an odd offset, or a 4-byte access at an offset that is not a multiple of 4 sets the error flag in the completion, returns data 0 and changes no state.
- R4: A 1-byte write is accepted only at offsets 0x0C (cache line size), 0x0D (latency timer) and 0x3C (interrupt line). At any other offset it sets the error flag and changes nothing.
- R5: A 2-byte write is accepted only at 0x04 (command), 0x06 (status) and 0x0C (cache line size in the low byte, latency timer in the high byte). At any other offset it sets the error flag and changes nothing.
- R6: A 4-byte write at 0x04 updates only the 16-bit command field and leaves status unchanged. A 4-byte write at an offset that is neither 0x04, a base address register (0x10 + 4*n, n from 0 to 5) nor the ROM base (0x30) has no effect and no error.
- R7: A 4-byte write of 0xFFFFFFFF to a base address register loads the complement of (size - 1) while keeping its type bits, and leaves its decode outputs unchanged.
- R8: A base address register whose bit 0 is 1 (I/O) keeps bits 1:0; one whose bit 0 is 0 (memory) keeps bits 3:0; all other bits take the written value.
- R9: A 4-byte write of 0xFFFFFFFE to the ROM base at 0x30 stores 0xFFFFFFFF; any other value is stored as written.
- R10: A non-sizing write to a base address register whose masked value (bit 0 cleared for I/O, bits 1:0 cleared for memory) is non-zero sets the decode base to that masked value plus the I/O or memory window offset, the last address to base + size - 1, and the valid flag, which stays set. A masked value of zero leaves the decode outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_offset | input | 6 | Byte offset into the header |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Completion strobe, one cycle after the request |
| rsp_err | output | 1 | Completion carries an illegal access |
| rsp_rdata | output | 32 | Read data, right-justified, zero for writes and errors |
| bar_base | output | NUM_BAR*ADDR_W | Decode base of each base address register |
| bar_last | output | NUM_BAR*ADDR_W | Last decoded address of each base address register |
| bar_valid | output | NUM_BAR | Decode window of each register has been set |

## Verification
A normal write to a base address register changes the register image and its decode base at the same edge, while a sizing write on the same register must change only the image. The bench interleaves all-ones writes, address writes and writes whose masked value is zero on I/O and memory registers of several sizes, both in directed sequences and in random traffic. After every access it compares the decode outputs of all six registers with its model, and it reads the registers back, so a sizing write that disturbs the decode window, or an address write that misses one of the two updates, is caught in the completion that follows.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;

   localparam int unsigned CFG_BYTES = 64;
   localparam int unsigned CFG_WORDS = CFG_BYTES / 4;
   localparam int unsigned OFF_W     = $clog2(CFG_BYTES);
   localparam int unsigned DW        = 32;
   localparam int unsigned MAX_BAR   = 6;

   // offsets whose position other logic depends on
   localparam logic [OFF_W-1:0] OFF_CMD  = OFF_W'(8'h04);
   localparam logic [OFF_W-1:0] OFF_STAT = OFF_W'(8'h06);
   localparam logic [OFF_W-1:0] OFF_CLS  = OFF_W'(8'h0C);
   localparam logic [OFF_W-1:0] OFF_LAT  = OFF_W'(8'h0D);
   localparam logic [OFF_W-1:0] OFF_BAR0 = OFF_W'(8'h10);
   localparam logic [OFF_W-1:0] OFF_ROM  = OFF_W'(8'h30);
   localparam logic [OFF_W-1:0] OFF_INTL = OFF_W'(8'h3C);

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_BYTE,
      ACC_HALF,
      ACC_WORD
   } acc_width_e;

   function automatic acc_width_e width_of(input logic [2:0] nbytes);
      case (nbytes)
         3'd1:    return ACC_BYTE;
         3'd2:    return ACC_HALF;
         3'd4:    return ACC_WORD;
         default: return ACC_NONE;
      endcase
   endfunction

   function automatic logic is_aligned(input acc_width_e w, input logic [1:0] lo);
      case (w)
         ACC_BYTE: return 1'b1;
         ACC_HALF: return ~lo[0];
         ACC_WORD: return lo == 2'b00;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/cfgspace_acc_dec.sv
module cfgspace_acc_dec
   import cfgspace_pkg::*;
#(
   parameter int unsigned NUM_BAR = MAX_BAR
) (
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [OFF_W-1:0]   req_offset,
   input  logic [2:0]         req_size,
   output acc_width_e         acc_width,
   output logic               acc_ok,
   output logic               wr_reject,
   output logic               we_cmd,
   output logic               we_stat,
   output logic               we_cls,
   output logic               we_lat,
   output logic               lat_from_hi,
   output logic               we_intl,
   output logic               we_rom,
   output logic [NUM_BAR-1:0] we_bar
);

   logic wr_go;
   logic byte_wr;
   logic half_wr;
   logic word_wr;
   logic byte_allowed;
   logic half_allowed;

   always_comb begin
      acc_width = width_of(req_size);
      acc_ok    = (acc_width != ACC_NONE) && is_aligned(acc_width, req_offset[1:0]);
      wr_go     = req_valid && req_write && acc_ok;
      byte_wr   = wr_go && (acc_width == ACC_BYTE);
      half_wr   = wr_go && (acc_width == ACC_HALF);
      word_wr   = wr_go && (acc_width == ACC_WORD);

      byte_allowed = (req_offset == OFF_CLS) || (req_offset == OFF_LAT) ||
                     (req_offset == OFF_INTL);
      half_allowed = (req_offset == OFF_CMD) || (req_offset == OFF_STAT) ||
                     (req_offset == OFF_CLS);

      wr_reject   = (byte_wr && !byte_allowed) || (half_wr && !half_allowed);

      we_cmd      = (half_wr || word_wr) && (req_offset == OFF_CMD);
      we_stat     = half_wr && (req_offset == OFF_STAT);
      we_cls      = (byte_wr || half_wr) && (req_offset == OFF_CLS);
      we_lat      = (byte_wr && (req_offset == OFF_LAT)) ||
                    (half_wr && (req_offset == OFF_CLS));
      lat_from_hi = half_wr;
      we_intl     = byte_wr && (req_offset == OFF_INTL);
      we_rom      = word_wr && (req_offset == OFF_ROM);
   end

   for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar_sel
      localparam logic [OFF_W-1:0] SLOT_OFF = OFF_W'(OFF_BAR0 + 4 * i);
      assign we_bar[i] = word_wr && (req_offset == SLOT_OFF);
   end

endmodule

// File: rtl/cfgspace_bar_slot.sv
module cfgspace_bar_slot
   import cfgspace_pkg::*;
#(
   parameter int unsigned     ADDR_W   = 40,
   parameter logic [DW-1:0]   BAR_INIT = '0,
   parameter logic [DW-1:0]   BAR_SIZE = DW'(16),
   parameter logic [ADDR_W-1:0] IO_WIN  = '0,
   parameter logic [ADDR_W-1:0] MEM_WIN = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     bar_val,
   output logic [ADDR_W-1:0] dec_base,
   output logic [ADDR_W-1:0] dec_last,
   output logic              dec_valid
);

   localparam bit            IS_IO     = BAR_INIT[0];
   localparam int unsigned   TYPE_BITS = IS_IO ? 2 : 4;
   localparam logic [DW-1:0] MIN_SIZE  = DW'(1) << TYPE_BITS;
   localparam logic [DW-1:0] SIZE_MASK = BAR_SIZE - DW'(1);
   localparam bit            SIZE_POW2 = (BAR_SIZE != '0) && ((BAR_SIZE & SIZE_MASK) == '0);

   if (ADDR_W < DW) begin : g_bad_addr_w
      $error("decode address width must cover the register width");
   end
   if (!SIZE_POW2) begin : g_bad_size
      $error("base address register size must be a power of two");
   end
   if (BAR_SIZE < MIN_SIZE) begin : g_small_size
      $error("base address register size below the minimum for its type");
   end

   logic [DW-1:0]     type_mask;
   logic [DW-1:0]     dec_mask;
   logic [ADDR_W-1:0] win_ofs;

   if (IS_IO) begin : g_io
      assign type_mask = DW'(32'h3);
      assign dec_mask  = ~DW'(32'h1);
      assign win_ofs   = IO_WIN;
   end else begin : g_mem
      assign type_mask = DW'(32'hF);
      assign dec_mask  = ~DW'(32'h3);
      assign win_ofs   = MEM_WIN;
   end

   logic [DW-1:0]     val_q;
   logic [ADDR_W-1:0] base_q;
   logic              valid_q;
   logic              sizing;
   logic [DW-1:0]     masked;

   assign sizing = (wdata == '1);
   assign masked = wdata & dec_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q   <= BAR_INIT;
         base_q  <= '0;
         valid_q <= 1'b0;
      end else if (we) begin
         if (sizing) begin
            val_q <= ~SIZE_MASK | (val_q & type_mask);
         end else begin
            val_q <= (wdata & ~type_mask) | (val_q & type_mask);
            if (masked != '0) begin
               base_q  <= ADDR_W'(masked) + win_ofs;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign bar_val   = val_q;
   assign dec_base  = base_q;
   assign dec_last  = base_q + ADDR_W'(SIZE_MASK);
   assign dec_valid = valid_q;

   // R8: type bits never move
   a_r8_type_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 $stable(val_q & type_mask));

   // R7: sizing answer has every bit at or above log2(size) set, all size bits clear
   a_r7_sizing_answer: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sizing) |=> ((val_q | SIZE_MASK) == '1) &&
                         ((val_q & SIZE_MASK & ~type_mask) == '0));

   // R7: sizing leaves the decode window alone
   a_r7_sizing_keeps_decode: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sizing) |=> ($stable(dec_base) && $stable(dec_valid)));

   // R10: once a window is set it stays set
   a_r10_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> dec_valid);

endmodule

// File: rtl/cfgspace_rd_mux.sv
module cfgspace_rd_mux
   import cfgspace_pkg::*;
(
   input  logic [CFG_WORDS*DW-1:0] words,
   input  logic [OFF_W-1:0]        offset,
   input  acc_width_e              width,
   output logic [DW-1:0]           rdata
);

   logic [DW-1:0] word_arr [CFG_WORDS];
   logic [DW-1:0] sel_word;
   logic [7:0]    sel_byte;

   for (genvar w = 0; w < CFG_WORDS; w++) begin : g_unpack
      assign word_arr[w] = words[w*DW +: DW];
   end

   always_comb begin
      sel_word = word_arr[offset[OFF_W-1:2]];
      case (offset[1:0])
         2'd0:    sel_byte = sel_word[7:0];
         2'd1:    sel_byte = sel_word[15:8];
         2'd2:    sel_byte = sel_word[23:16];
         default: sel_byte = sel_word[31:24];
      endcase
      case (width)
         ACC_WORD: rdata = sel_word;
         ACC_HALF: rdata = {16'h0, offset[1] ? sel_word[31:16] : sel_word[15:0]};
         ACC_BYTE: rdata = {24'h0, sel_byte};
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
   import cfgspace_pkg::*;
#(
   parameter int unsigned             NUM_BAR   = MAX_BAR,
   parameter int unsigned             ADDR_W    = 40,
   parameter logic [ADDR_W-1:0]       IO_WIN    = ADDR_W'(40'h01_0000_0000),
   parameter logic [ADDR_W-1:0]       MEM_WIN   = ADDR_W'(40'h02_0000_0000),
   parameter logic [15:0]             VENDOR_ID = 16'h1A2B,
   parameter logic [15:0]             DEVICE_ID = 16'h3C4D,
   parameter logic [31:0]             CLASS_REV = 32'h0200_0011,
   parameter logic [7:0]              HDR_TYPE  = 8'h00,
   parameter logic [7:0]              SELF_TEST = 8'h00,
   parameter logic [15:0]             INIT_CMD  = 16'h0000,
   parameter logic [15:0]             INIT_STAT = 16'h0290,
   parameter logic [7:0]              INIT_CLS  = 8'h08,
   parameter logic [7:0]              INIT_LAT  = 8'h20,
   parameter logic [MAX_BAR*DW-1:0]   BAR_INIT  = {32'h0, 32'h4, 32'h1, 32'h0, 32'h8, 32'h1},
   parameter logic [MAX_BAR*DW-1:0]   BAR_SIZE  = {32'h40, 32'h0010_0000, 32'h4,
                                                  32'h10, 32'h1000, 32'h100},
   parameter logic [31:0]             CIS_PTR   = 32'h0,
   parameter logic [31:0]             SUBSYS    = 32'h5566_7788,
   parameter logic [31:0]             INIT_ROM  = 32'h0,
   parameter logic [7:0]              INIT_INTL = 8'h0B,
   parameter logic [7:0]              INT_PIN   = 8'h01,
   parameter logic [7:0]              MIN_GNT   = 8'h02,
   parameter logic [7:0]              MAX_LAT   = 8'h03
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [OFF_W-1:0]          req_offset,
   input  logic [2:0]                req_size,
   input  logic [DW-1:0]             req_wdata,
   output logic                      rsp_valid,
   output logic                      rsp_err,
   output logic [DW-1:0]             rsp_rdata,
   output logic [NUM_BAR*ADDR_W-1:0] bar_base,
   output logic [NUM_BAR*ADDR_W-1:0] bar_last,
   output logic [NUM_BAR-1:0]        bar_valid
);

   localparam int unsigned BAR_WORD0 = OFF_BAR0 / 4;
   localparam int unsigned ROM_WORD  = OFF_ROM / 4;

   if (NUM_BAR < 1 || NUM_BAR > MAX_BAR) begin : g_bad_num_bar
      $error("number of base address registers out of range");
   end

   acc_width_e         acc_width;
   logic               acc_ok;
   logic               wr_reject;
   logic               we_cmd, we_stat, we_cls, we_lat, lat_from_hi, we_intl, we_rom;
   logic [NUM_BAR-1:0] we_bar;

   cfgspace_acc_dec #(.NUM_BAR(NUM_BAR)) u_dec (
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_offset  (req_offset),
      .req_size    (req_size),
      .acc_width   (acc_width),
      .acc_ok      (acc_ok),
      .wr_reject   (wr_reject),
      .we_cmd      (we_cmd),
      .we_stat     (we_stat),
      .we_cls      (we_cls),
      .we_lat      (we_lat),
      .lat_from_hi (lat_from_hi),
      .we_intl     (we_intl),
      .we_rom      (we_rom),
      .we_bar      (we_bar)
   );

   // writable fields
   logic [15:0] cmd_q, stat_q;
   logic [7:0]  cls_q, lat_q, intl_q;
   logic [31:0] rom_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= INIT_CMD;
         stat_q <= INIT_STAT;
         cls_q  <= INIT_CLS;
         lat_q  <= INIT_LAT;
         intl_q <= INIT_INTL;
         rom_q  <= INIT_ROM;
      end else begin
         if (we_cmd)  cmd_q  <= req_wdata[15:0];
         if (we_stat) stat_q <= req_wdata[15:0];
         if (we_cls)  cls_q  <= req_wdata[7:0];
         if (we_lat)  lat_q  <= lat_from_hi ? req_wdata[15:8] : req_wdata[7:0];
         if (we_intl) intl_q <= req_wdata[7:0];
         if (we_rom)  rom_q  <= (req_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : req_wdata;
      end
   end

   // base address registers
   logic [DW-1:0] bar_val [NUM_BAR];

   for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
      cfgspace_bar_slot #(
         .ADDR_W   (ADDR_W),
         .BAR_INIT (BAR_INIT[i*DW +: DW]),
         .BAR_SIZE (BAR_SIZE[i*DW +: DW]),
         .IO_WIN   (IO_WIN),
         .MEM_WIN  (MEM_WIN)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .we        (we_bar[i]),
         .wdata     (req_wdata),
         .bar_val   (bar_val[i]),
         .dec_base  (bar_base[i*ADDR_W +: ADDR_W]),
         .dec_last  (bar_last[i*ADDR_W +: ADDR_W]),
         .dec_valid (bar_valid[i])
      );
   end

   // header image, one 32-bit word per slot
   logic [CFG_WORDS*DW-1:0] image;

   for (genvar w = 0; w < CFG_WORDS; w++) begin : g_image
      if (w >= BAR_WORD0 && w < BAR_WORD0 + NUM_BAR) begin : g_bar_word
         assign image[w*DW +: DW] = bar_val[w - BAR_WORD0];
      end else if (w == 0) begin : g_id
         assign image[w*DW +: DW] = {DEVICE_ID, VENDOR_ID};
      end else if (w == 1) begin : g_cmd
         assign image[w*DW +: DW] = {stat_q, cmd_q};
      end else if (w == 2) begin : g_class
         assign image[w*DW +: DW] = CLASS_REV;
      end else if (w == 3) begin : g_misc
         assign image[w*DW +: DW] = {SELF_TEST, HDR_TYPE, lat_q, cls_q};
      end else if (w == 10) begin : g_cis
         assign image[w*DW +: DW] = CIS_PTR;
      end else if (w == 11) begin : g_subsys
         assign image[w*DW +: DW] = SUBSYS;
      end else if (w == ROM_WORD) begin : g_rom
         assign image[w*DW +: DW] = rom_q;
      end else if (w == CFG_WORDS - 1) begin : g_irq
         assign image[w*DW +: DW] = {MAX_LAT, MIN_GNT, INT_PIN, intl_q};
      end else begin : g_zero
         assign image[w*DW +: DW] = '0;
      end
   end

   logic [DW-1:0] rd_word;

   cfgspace_rd_mux u_rd (
      .words  (image),
      .offset (req_offset),
      .width  (acc_width),
      .rdata  (rd_word)
   );

   // completion, one cycle after the request
   logic          rsp_valid_q, rsp_err_q;
   logic [DW-1:0] rsp_rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= req_valid;
         rsp_err_q   <= req_valid && (!acc_ok || wr_reject);
         rsp_rdata_q <= (req_valid && !req_write && acc_ok) ? rd_word : '0;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_err   = rsp_err_q;
   assign rsp_rdata = rsp_rdata_q;

   // R2: completion timing
   a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r2_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R3: bad width or alignment completes with error and no data
   a_r3_bad_access: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (width_of(req_size) == ACC_NONE ||
                     !is_aligned(width_of(req_size), req_offset[1:0])))
      |=> (rsp_err && rsp_rdata == '0 && $stable(cmd_q) && $stable(rom_q)));

   // R6: a word write at the command offset never touches status
   a_r6_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == 3'd4 && req_offset == OFF_CMD)
      |=> (!rsp_err && $stable(stat_q)));

   // R9: ROM sizing pattern
   a_r9_rom_sizing: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == 3'd4 && req_offset == OFF_ROM &&
       req_wdata == 32'hFFFF_FFFE) |=> (rom_q == 32'hFFFF_FFFF));

   // R4: a byte write outside the three writable bytes is refused
   a_r4_byte_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == 3'd1 && req_offset != OFF_CLS &&
       req_offset != OFF_LAT && req_offset != OFF_INTL) |=> rsp_err);

endmodule

// File: tb/cfgspace_regfile_bench.sv
module cfgspace_regfile_bench;

   localparam int NB = 6;
   localparam int AW = 40;
   localparam logic [AW-1:0] IOW  = 40'h01_0000_0000;
   localparam logic [AW-1:0] MEMW = 40'h02_0000_0000;
   localparam logic [NB*32-1:0] B_INIT = {32'h0, 32'h4, 32'h1, 32'h0, 32'h8, 32'h1};
   localparam logic [NB*32-1:0] B_SIZE = {32'h40, 32'h0010_0000, 32'h4,
                                          32'h10, 32'h1000, 32'h100};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [5:0]        req_offset = '0;
   logic [2:0]        req_size = '0;
   logic [31:0]       req_wdata = '0;
   logic              rsp_valid, rsp_err;
   logic [31:0]       rsp_rdata;
   logic [NB*AW-1:0]  bar_base, bar_last;
   logic [NB-1:0]     bar_valid;

   cfgspace_regfile #(
      .NUM_BAR(NB), .ADDR_W(AW), .IO_WIN(IOW), .MEM_WIN(MEMW),
      .VENDOR_ID(16'h1A2B), .DEVICE_ID(16'h3C4D), .CLASS_REV(32'h0200_0011),
      .HDR_TYPE(8'h00), .SELF_TEST(8'h00), .INIT_CMD(16'h0000), .INIT_STAT(16'h0290),
      .INIT_CLS(8'h08), .INIT_LAT(8'h20), .BAR_INIT(B_INIT), .BAR_SIZE(B_SIZE),
      .CIS_PTR(32'h0), .SUBSYS(32'h5566_7788), .INIT_ROM(32'h0), .INIT_INTL(8'h0B),
      .INT_PIN(8'h01), .MIN_GNT(8'h02), .MAX_LAT(8'h03)
   ) u_cfgspace_regfile (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bar_base(bar_base), .bar_last(bar_last), .bar_valid(bar_valid)
   );

   always #4 clk = ~clk;

   int  checks = 0;
   int  failures = 0;
   bit  finished = 0;

   // reference model
   logic [7:0]    m [64];
   logic [AW-1:0] mbase [NB];
   logic [AW-1:0] mlast [NB];
   logic          mvalid [NB];

   task automatic put_word(input int idx, input logic [31:0] v);
      for (int k = 0; k < 4; k++) m[idx*4+k] = v[8*k +: 8];
   endtask

   function automatic logic [31:0] get_word(input int off);
      return {m[off+3], m[off+2], m[off+1], m[off]};
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 64; k++) m[k] = 8'h00;
      put_word(0, 32'h3C4D_1A2B);
      put_word(1, 32'h0290_0000);
      put_word(2, 32'h0200_0011);
      put_word(3, 32'h0000_2008);
      for (int i = 0; i < NB; i++) put_word(4 + i, B_INIT[i*32 +: 32]);
      put_word(11, 32'h5566_7788);
      put_word(15, 32'h0302_010B);
      for (int i = 0; i < NB; i++) begin
         mbase[i] = '0; mlast[i] = '0; mvalid[i] = 1'b0;
      end
   endtask

   task automatic model_bar(input int i, input logic [31:0] d);
      logic [31:0] cur, low, sz, nv, msk;
      bit io;
      cur = get_word(16 + 4*i);
      io  = cur[0];
      low = io ? 32'h3 : 32'hF;
      sz  = B_SIZE[i*32 +: 32];
      if (d == 32'hFFFF_FFFF) begin
         nv = ~(sz - 32'd1) | (cur & low);
      end else begin
         nv  = (d & ~low) | (cur & low);
         msk = io ? (d & ~32'h1) : (d & ~32'h3);
         if (msk != 0) begin
            mbase[i]  = AW'(msk) + (io ? IOW : MEMW);
            mlast[i]  = mbase[i] + AW'(sz - 32'd1);
            mvalid[i] = 1'b1;
         end
      end
      put_word(4 + i, nv);
   endtask

   task automatic model_apply(input bit wr, input int off, input int sz,
                              input logic [31:0] d, output bit e, output logic [31:0] rd);
      bit legal;
      legal = ((sz == 1) || (sz == 2 && off % 2 == 0) || (sz == 4 && off % 4 == 0));
      e  = 1'b0;
      rd = '0;
      if (!legal) begin
         e = 1'b1;
      end else if (!wr) begin
         for (int k = 0; k < sz; k++) rd[8*k +: 8] = m[off+k];
      end else if (sz == 1) begin
         if (off == 12 || off == 13 || off == 60) m[off] = d[7:0];
         else e = 1'b1;
      end else if (sz == 2) begin
         if (off == 4 || off == 6 || off == 12) begin
            m[off] = d[7:0]; m[off+1] = d[15:8];
         end else e = 1'b1;
      end else begin
         if (off >= 16 && off < 16 + 4*NB) model_bar((off - 16) / 4, d);
         else if (off == 48) put_word(12, (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d);
         else if (off == 4) begin m[4] = d[7:0]; m[5] = d[15:8]; end
      end
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_decode(input string tag);
      for (int i = 0; i < NB; i++) begin
         check(bar_valid[i] == mvalid[i], tag, "decode valid", 64'(bar_valid[i]), 64'(mvalid[i]));
         if (mvalid[i]) begin
            check(bar_base[i*AW +: AW] == mbase[i], tag, "decode base",
                  64'(bar_base[i*AW +: AW]), 64'(mbase[i]));
            check(bar_last[i*AW +: AW] == mlast[i], tag, "decode last",
                  64'(bar_last[i*AW +: AW]), 64'(mlast[i]));
         end
      end
   endtask

   task automatic access(input bit wr, input int off, input int sz,
                         input logic [31:0] d, input string tag);
      bit          e_exp;
      logic [31:0] rd_exp;
      model_apply(wr, off, sz, d, e_exp, rd_exp);
      @(negedge clk);
      req_valid  = 1'b1;
      req_write  = wr;
      req_offset = 6'(off);
      req_size   = 3'(sz);
      req_wdata  = d;
      @(negedge clk);
      check(rsp_valid == 1'b1, "R2", "completion strobe", 64'(rsp_valid), 64'd1);
      check(rsp_err == e_exp, tag, "error flag", 64'(rsp_err), 64'(e_exp));
      check(rsp_rdata == rd_exp, tag, "read data", 64'(rsp_rdata), 64'(rd_exp));
      check_decode((tag == "R7") ? "R7" : "R10");
      req_valid = 1'b0;
   endtask

   task automatic rd(input int off, input int sz, input string tag);
      access(1'b0, off, sz, 32'h0, tag);
   endtask

   task automatic wr(input int off, input int sz, input logic [31:0] d, input string tag);
      access(1'b1, off, sz, d, tag);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
   end

   initial begin : main
      int seed_val;
      seed_val = int'($urandom(32'h00C0_FFEE));
      model_reset();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset image and decode outputs
      check(rsp_valid == 1'b0, "R1", "idle completion", 64'(rsp_valid), 64'd0);
      check(bar_valid == '0, "R1", "decode valid at reset", 64'(bar_valid), 64'd0);
      for (int w = 0; w < 16; w++) rd(w*4, 4, "R1");

      // R2: widths and byte order
      rd(1, 1, "R2"); rd(2, 2, "R2"); rd(14, 1, "R2"); rd(62, 2, "R2"); rd(0, 2, "R2");

      // R3: illegal widths and alignment
      rd(0, 3, "R3"); rd(4, 0, "R3"); rd(8, 5, "R3"); rd(1, 2, "R3"); rd(2, 4, "R3");
      wr(12, 3, 32'h0000_5555, "R3"); wr(17, 4, 32'h1234_5678, "R3");
      wr(5, 2, 32'h0000_7777, "R3"); rd(12, 4, "R3"); rd(4, 4, "R3");

      // R4: byte writes
      wr(12, 1, 32'h0000_0040, "R4"); wr(13, 1, 32'h0000_0080, "R4");
      wr(60, 1, 32'h0000_00A5, "R4"); wr(0, 1, 32'h0000_00FF, "R4");
      wr(4, 1, 32'h0000_00FF, "R4"); wr(16, 1, 32'h0000_00FF, "R4");
      rd(12, 4, "R4"); rd(60, 4, "R4"); rd(0, 4, "R4"); rd(4, 4, "R4");

      // R5: half writes
      wr(4, 2, 32'h0000_0147, "R5"); wr(6, 2, 32'h0000_BEEF, "R5");
      wr(12, 2, 32'h0000_9910, "R5"); wr(60, 2, 32'h0000_1111, "R5");
      wr(16, 2, 32'h0000_2222, "R5"); wr(2, 2, 32'h0000_3333, "R5");
      rd(4, 4, "R5"); rd(12, 4, "R5"); rd(60, 4, "R5"); rd(16, 4, "R5");

      // R6: word write at command and ignored word writes
      wr(4, 4, 32'hABCD_1234, "R6"); rd(4, 4, "R6");
      wr(8, 4, 32'hFFFF_FFFF, "R6"); wr(0, 4, 32'h0, "R6"); wr(60, 4, 32'h0, "R6");
      wr(12, 4, 32'h0, "R6"); wr(40, 4, 32'h1, "R6");
      rd(8, 4, "R6"); rd(0, 4, "R6"); rd(60, 4, "R6"); rd(12, 4, "R6"); rd(40, 4, "R6");

      // R7: sizing of every register
      for (int i = 0; i < NB; i++) begin
         wr(16 + 4*i, 4, 32'hFFFF_FFFF, "R7");
         rd(16 + 4*i, 4, "R7");
      end

      // R8 and R10: address writes on I/O and memory registers
      wr(16, 4, 32'h0000_1002, "R8");  rd(16, 4, "R8");
      wr(20, 4, 32'hC000_0007, "R8");  rd(20, 4, "R8");
      wr(28, 4, 32'h0000_2FFC, "R8");  rd(28, 4, "R8");
      wr(32, 4, 32'hFFFF_FFF0, "R10"); rd(32, 4, "R10");
      wr(24, 4, 32'h0000_0002, "R10"); wr(36, 4, 32'h0000_0003, "R10");
      wr(16, 4, 32'h0000_0001, "R10"); rd(16, 4, "R10");
      wr(20, 4, 32'hFFFF_FFFF, "R7");  rd(20, 4, "R7");
      wr(20, 4, 32'hD000_0000, "R10");

      // R9: ROM base
      wr(48, 4, 32'hFFFF_FFFE, "R9"); rd(48, 4, "R9"); rd(50, 2, "R9");
      wr(48, 4, 32'h1234_5678, "R9"); rd(48, 4, "R9");
      wr(48, 4, 32'hFFFF_FFFF, "R9"); rd(48, 4, "R9");

      // random traffic
      for (int n = 0; n < 800; n++) begin
         int          off, sz, pick;
         bit          w;
         logic [31:0] d;
         string       tag;
         pick = int'($urandom % 8);
         case (pick)
            0, 1:    sz = 1;
            2:       sz = 2;
            3, 4, 5: sz = 4;
            6:       sz = 3;
            default: sz = int'($urandom % 8);
         endcase
         off = int'($urandom % 64);
         if (($urandom % 5) != 0 && (sz == 2 || sz == 4)) off = off - (off % sz);
         if (($urandom % 3) == 0 && sz == 4) off = 16 + 4 * int'($urandom % NB);
         w = ($urandom % 2) == 1;
         case ($urandom % 8)
            0, 1:    d = 32'hFFFF_FFFF;
            2:       d = 32'hFFFF_FFFE;
            3:       d = 32'($urandom % 4);
            default: d = $urandom;
         endcase
         if (!((sz == 1) || (sz == 2 && off % 2 == 0) || (sz == 4 && off % 4 == 0))) tag = "R3";
         else if (!w) tag = "R2";
         else if (sz == 1) tag = "R4";
         else if (sz == 2) tag = "R5";
         else if (off >= 16 && off < 16 + 4*NB) tag = (d == 32'hFFFF_FFFF) ? "R7" : "R8";
         else if (off == 48) tag = "R9";
         else tag = "R6";
         access(w, off, sz, d, tag);
      end

      // final image sweep
      for (int w = 0; w < 16; w++) rd(w*4, 4, "R2");
      summary();
   end

endmodule